// File: doc/BRIEF.md
# Three-Channel Match Timer with Snapshot Capture

The block holds three independent up-counters that advance on a shared tick-enable input. That input stands for a slower functional clock that is sampled in the fast register clock domain. Each channel has three match comparators. A match sets a sticky status bit and can raise that channel's interrupt line. A per-channel preload select names one comparator whose match reloads the counter from a preload value. This gives periodic timing, and with a compare value of all ones it gives a free-running wrap.

Software uses a single-cycle word-addressed write port and a combinational read port. To read a running counter without tearing, software writes a capture request that names the channel. A small sequencer then waits a fixed number of tick cycles and copies the count into a snapshot register. Software reads the value from that register.

The capture sequencer has two states. In `CAP_IDLE`, a request write moves it to `CAP_WAIT` (transition *accept*). In `CAP_WAIT`, it counts tick cycles. On the fourth tick it latches the count and returns to `CAP_IDLE` (transition *complete*). In every other cycle it stays where it is.

Word address map (default parameters): match registers at 0–8, count 9–11, status 12–14, interrupt enable 15–17, preload value 18–20, preload select 21–23, status clear 24–26, count enable 27, capture 28.

Top module: `tri_match_timer`

## Requirements
- R1: After reset, every readable register reads zero and all `irq` bits are low.
- R2: Match comparator k of channel c is read and written at word address 3*c+k.
- R3: A counter advances by one only in cycles where `tick_en` is high and bit c of the count-enable register (address 27, bit c = channel c) is set. In all other cycles it holds.
- R4: A write to a count register loads the written value. The write takes precedence over an advance in the same cycle.
- R5: Preload select 0 disables reload. Values 1, 2 and 3 select comparator 0, 1 and 2. In an advancing cycle where the count equals the selected match value, the next count is the preload value.
- R6: With compare value 0xFFFFFFFF and preload 0, or with reload disabled, the count following 0xFFFFFFFF is 0.
- R7: In an advancing cycle where the count equals match k, status bit k of that channel is set. It stays set until cleared.
- R8: `irq[c]` is high exactly when some status bit of channel c has its interrupt-enable bit (same bit position) set.
- R9: Writing 1 to bit k of a channel's clear register clears status bit k. Bits written 0 are unaffected. A match in the same cycle wins over the clear.
- R10: A write to address 28 with bit 0 set requests a capture of the channel in bits 9:8. On the fourth `tick_en` cycle after the request, the snapshot takes the count value present in that cycle, before any advance. Reading address 28 returns the snapshot.
- R11: While a capture is pending, reads of address 28 return the previous snapshot and further requests are ignored. A capture write with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Functional tick enable, one cycle per tick |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 3 | Per-channel interrupt |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a comparator match setting a status bit and a software clear of that same bit. The bench writes the count to a match value with ticks held off, then in one cycle raises `tick_en` and writes the clear. It judges the result by reading back a set status bit and a reloaded count. The second pair is a counter advance and the capture latch. A running channel is requested and read back as the count seen before the request plus five, while reads one tick earlier still show the old snapshot.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [0:0] {
        CAP_IDLE = 1'b0,
        CAP_WAIT = 1'b1
    } cap_state_e;

    localparam int CAP_REQ_BIT = 0;
    localparam int CAP_CH_LSB  = 8;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int NCMP = 3,
    parameter int DW   = 32,
    parameter int SW   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 run,
    input  logic [DW-1:0]        wdata,
    input  logic [NCMP-1:0]      wr_match,
    input  logic                 wr_cnt,
    input  logic                 wr_ie,
    input  logic                 wr_pre,
    input  logic                 wr_sel,
    input  logic                 wr_clr,
    output logic [DW-1:0]        cnt,
    output logic [NCMP*DW-1:0]   match_flat,
    output logic [NCMP-1:0]      status,
    output logic [NCMP-1:0]      ie,
    output logic [DW-1:0]        pre,
    output logic [SW-1:0]        sel,
    output logic                 irq
);
    logic            step;
    logic [NCMP-1:0] hit;
    logic            reload;
    logic [NCMP-1:0] clr_mask;

    assign step = tick & run;

    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
        logic [DW-1:0] match_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           match_q <= '0;
            else if (wr_match[k]) match_q <= wdata;
        end
        assign match_flat[k*DW +: DW] = match_q;
        assign hit[k] = step && (cnt == match_q);
    end

    always_comb begin
        reload = 1'b0;
        for (int k = 0; k < NCMP; k++) begin
            if (sel == SW'(k + 1) && hit[k]) reload = 1'b1;
        end
    end

    assign clr_mask = wr_clr ? wdata[NCMP-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            status <= '0;
            ie     <= '0;
            pre    <= '0;
            sel    <= '0;
        end else begin
            if (wr_cnt)      cnt <= wdata;
            else if (reload) cnt <= pre;
            else if (step)   cnt <= cnt + 1'b1;
            status <= (status & ~clr_mask) | hit;
            if (wr_ie)  ie  <= wdata[NCMP-1:0];
            if (wr_pre) pre <= wdata;
            if (wr_sel) sel <= wdata[SW-1:0];
        end
    end

    assign irq = |(status & ie);
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 32,
    parameter int LAT = 4,
    parameter int CHW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req,
    input  logic [CHW-1:0]    req_ch,
    input  logic [NCH*DW-1:0] cnt_flat,
    output logic [DW-1:0]     snap
);
    localparam int TCW = $clog2(LAT + 1);

    cap_state_e     state_q, state_d;
    logic [TCW-1:0] tcnt_q;
    logic [CHW-1:0] ch_q;
    logic           done;
    logic [DW-1:0]  pick;

    assign done = (state_q == CAP_WAIT) && tick && (tcnt_q == TCW'(LAT - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE: if (req)  state_d = CAP_WAIT;
            CAP_WAIT: if (done) state_d = CAP_IDLE;
            default:            state_d = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pick = '0;
        for (int c = 0; c < NCH; c++) begin
            if (ch_q == CHW'(c)) pick = cnt_flat[c*DW +: DW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            ch_q   <= '0;
            snap   <= '0;
        end else begin
            unique case (state_q)
                CAP_IDLE: begin
                    if (req) begin
                        ch_q   <= req_ch;
                        tcnt_q <= '0;
                    end
                end
                CAP_WAIT: begin
                    if (done)      snap   <= pick;
                    else if (tick) tcnt_q <= tcnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tri_match_timer.sv
module tri_match_timer
    import tmr_pkg::*;
#(
    parameter int NCH  = 3,
    parameter int NCMP = 3,
    parameter int DW   = 32,
    parameter int AW   = 6,
    parameter int LAT  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_en,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic [NCH-1:0] irq
);
    localparam int NM      = NCH * NCMP;
    localparam int SW      = $clog2(NCMP + 1);
    localparam int CHW     = $clog2(NCH);
    localparam int A_MATCH = 0;
    localparam int A_CNT   = A_MATCH + NM;
    localparam int A_STAT  = A_CNT + NCH;
    localparam int A_IE    = A_STAT + NCH;
    localparam int A_PRE   = A_IE + NCH;
    localparam int A_SEL   = A_PRE + NCH;
    localparam int A_CLR   = A_SEL + NCH;
    localparam int A_CEN   = A_CLR + NCH;
    localparam int A_CAP   = A_CEN + 1;

    logic [NCH*DW-1:0]    cnt_flat;
    logic [NM*DW-1:0]     match_all;
    logic [NCH*NCMP-1:0]  st_flat;
    logic [NCH*NCMP-1:0]  ie_flat;
    logic [NCH*DW-1:0]    pre_flat;
    logic [NCH*SW-1:0]    sel_flat;
    logic [NCH-1:0]       cen_q;
    logic [DW-1:0]        snap;
    logic                 cap_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    cen_q <= '0;
        else if (reg_we && reg_addr == AW'(A_CEN))     cen_q <= reg_wdata[NCH-1:0];
    end

    assign cap_req = reg_we && (reg_addr == AW'(A_CAP)) && reg_wdata[CAP_REQ_BIT];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [NCMP-1:0] wr_m;
        for (genvar k = 0; k < NCMP; k++) begin : g_wm
            assign wr_m[k] = reg_we && (reg_addr == AW'(A_MATCH + c*NCMP + k));
        end
        tmr_channel #(.NCMP(NCMP), .DW(DW), .SW(SW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick_en),
            .run        (cen_q[c]),
            .wdata      (reg_wdata),
            .wr_match   (wr_m),
            .wr_cnt     (reg_we && reg_addr == AW'(A_CNT + c)),
            .wr_ie      (reg_we && reg_addr == AW'(A_IE + c)),
            .wr_pre     (reg_we && reg_addr == AW'(A_PRE + c)),
            .wr_sel     (reg_we && reg_addr == AW'(A_SEL + c)),
            .wr_clr     (reg_we && reg_addr == AW'(A_CLR + c)),
            .cnt        (cnt_flat[c*DW +: DW]),
            .match_flat (match_all[c*NCMP*DW +: NCMP*DW]),
            .status     (st_flat[c*NCMP +: NCMP]),
            .ie         (ie_flat[c*NCMP +: NCMP]),
            .pre        (pre_flat[c*DW +: DW]),
            .sel        (sel_flat[c*SW +: SW]),
            .irq        (irq[c])
        );
    end

    tmr_capture #(.NCH(NCH), .DW(DW), .LAT(LAT), .CHW(CHW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .req      (cap_req),
        .req_ch   (reg_wdata[CAP_CH_LSB +: CHW]),
        .cnt_flat (cnt_flat),
        .snap     (snap)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NM; i++) begin
            if (reg_addr == AW'(A_MATCH + i)) reg_rdata = match_all[i*DW +: DW];
        end
        for (int c = 0; c < NCH; c++) begin
            if (reg_addr == AW'(A_CNT + c))  reg_rdata = cnt_flat[c*DW +: DW];
            if (reg_addr == AW'(A_STAT + c)) reg_rdata = DW'(st_flat[c*NCMP +: NCMP]);
            if (reg_addr == AW'(A_IE + c))   reg_rdata = DW'(ie_flat[c*NCMP +: NCMP]);
            if (reg_addr == AW'(A_PRE + c))  reg_rdata = pre_flat[c*DW +: DW];
            if (reg_addr == AW'(A_SEL + c))  reg_rdata = DW'(sel_flat[c*SW +: SW]);
        end
        if (reg_addr == AW'(A_CEN)) reg_rdata = DW'(cen_q);
        if (reg_addr == AW'(A_CAP)) reg_rdata = snap;
    end
endmodule

// File: rtl/tmt_checker.sv
module tmt_checker #(
    parameter int NCH  = 3,
    parameter int NCMP = 3,
    parameter int DW   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_en,
    input logic                reg_we,
    input logic [NCH-1:0]      irq,
    input logic [NCH*DW-1:0]   cnt_flat,
    input logic [NCH*NCMP-1:0] st_flat,
    input logic [NCH*NCMP-1:0] ie_flat,
    input logic [NCH-1:0]      cen,
    input logic [DW-1:0]       snap
);
    // R3
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !reg_we) |=> $stable(cnt_flat));

    for (genvar c = 0; c < NCH; c++) begin : g_hold
        // R3
        stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cen[c] && !reg_we) |=> $stable(cnt_flat[c*DW +: DW]));
    end

    // R7
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> (($past(st_flat) & ~st_flat) == '0));

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_flat == '0) |-> (irq == '0));

    // R10
    snap_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(snap));
endmodule

bind tri_match_timer tmt_checker #(.NCH(NCH), .NCMP(NCMP), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .reg_we   (reg_we),
    .irq      (irq),
    .cnt_flat (cnt_flat),
    .st_flat  (st_flat),
    .ie_flat  (ie_flat),
    .cen      (cen_q),
    .snap     (snap)
);

// File: tb/tri_match_timer_test.sv
module tri_match_timer_test;
    localparam int A_CNT = 9, A_STAT = 12, A_IE = 15, A_PRE = 18, A_SEL = 21;
    localparam int A_CLR = 24, A_CEN = 27, A_CAP = 28;

    logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [2:0]  irq;
    int checks = 0, fails = 0;
    logic [31:0] v, d;

    tri_match_timer uut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

    always #2 clk = ~clk;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] dat);
        @(negedge clk); reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = dat;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] dat);
        reg_addr = 6'(a); #1; dat = reg_rdata;
    endtask

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tk(3); rst_n = 1'b1; tk(1);
        // R1 reset state
        for (int a = 0; a <= A_CAP; a++) begin rd(a, d); chk("R1", d, 0); end
        chk("R1 irq", 32'(irq), 0);
        // R2 match bank indexing
        for (int i = 0; i < 9; i++) wr(i, 32'hA500_0000 + 32'(i*17));
        for (int i = 0; i < 9; i++) begin rd(i, d); chk("R2", d, 32'hA500_0000 + 32'(i*17)); end
        // R3 gating by tick and enable
        wr(A_CNT, 10); wr(A_CNT+1, 20); wr(A_CNT+2, 30); wr(A_CEN, 3'b101);
        tk(5);
        rd(A_CNT, d); chk("R3 no tick", d, 10);
        tick_en = 1'b1; tk(6); tick_en = 1'b0;
        rd(A_CNT, d); chk("R3", d, 16);
        rd(A_CNT+1, d); chk("R3 disabled", d, 20);
        rd(A_CNT+2, d); chk("R3", d, 36);
        for (int i = 0; i < 8; i++) begin tick_en = (i % 2) == 1; tk(1); end
        tick_en = 1'b0;
        rd(A_CNT, d); chk("R3 sparse ticks", d, 20);
        // R4 write beats advance
        tick_en = 1'b1; wr(A_CNT, 1000); rd(A_CNT, d); chk("R4", d, 1000);
        tick_en = 1'b0; wr(A_CEN, 0);
        // R5 / R7 sweep over channel and preload select
        for (int c = 0; c < 3; c++) begin
            for (int s = 0; s < 4; s++) begin
                int k, m;
                k = (s == 0) ? 0 : s - 1;
                m = 7 + k*3;
                for (int j = 0; j < 3; j++) wr(c*3 + j, (j == k) ? 32'(m) : 32'hFFFF_0000);
                wr(A_PRE+c, 32'(500 + c)); wr(A_SEL+c, 32'(s)); wr(A_CLR+c, 7);
                wr(A_CNT+c, 0); wr(A_CEN, 32'(1 << c));
                tick_en = 1'b1; tk(m + 1); tick_en = 1'b0;
                rd(A_CNT+c, d); chk("R5", d, (s == 0) ? 32'(m + 1) : 32'(500 + c));
                rd(A_STAT+c, d); chk("R7", d, 32'(1 << k));
                wr(A_CEN, 0);
            end
        end
        // R6 wrap with reload on ch0 and without on ch1
        wr(0, 32'hFFFF_FFFF); wr(A_PRE, 0); wr(A_SEL, 1); wr(A_CNT, 32'hFFFF_FFFD);
        for (int j = 3; j < 6; j++) wr(j, 5);
        wr(A_SEL+1, 0); wr(A_CNT+1, 32'hFFFF_FFFD); wr(A_CLR, 7); wr(A_CEN, 3);
        tick_en = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            tk(1);
            rd(A_CNT, d);   chk("R6 reload", d, 32'hFFFF_FFFD + 32'(i));
            rd(A_CNT+1, d); chk("R6 natural", d, 32'hFFFF_FFFD + 32'(i));
        end
        tick_en = 1'b0;
        // R8 interrupt masking
        wr(A_CLR+1, 7); wr(A_CLR+2, 7);
        rd(A_STAT, d); chk("R7 wrap match", d, 1);
        chk("R8 masked", 32'(irq), 0);
        wr(A_IE, 3'b110); chk("R8 other bits", 32'(irq), 0);
        wr(A_IE, 3'b001); chk("R8 enabled", 32'(irq), 1);
        // R9 clear
        wr(A_CLR, 2); rd(A_STAT, d); chk("R9 zero bits kept", d, 1);
        chk("R9 irq kept", 32'(irq), 1);
        wr(A_CLR, 1); rd(A_STAT, d); chk("R9 cleared", d, 0);
        chk("R8 after clear", 32'(irq), 0);
        // R9 match and clear in one cycle
        wr(A_CNT, 32'hFFFF_FFFF);
        @(negedge clk); reg_we = 1'b1; reg_addr = 6'(A_CLR); reg_wdata = 1; tick_en = 1'b1;
        @(negedge clk); reg_we = 1'b0; tick_en = 1'b0;
        rd(A_STAT, d); chk("R9 set wins", d, 1);
        rd(A_CNT, d); chk("R5 reload same cycle", d, 0);
        // R10 capture on a stopped channel, ticks gated
        wr(A_CEN, 0); wr(A_CNT+2, 32'h1234_5678);
        wr(A_CAP, 32'h0000_0201);
        tk(10); rd(A_CAP, d); chk("R11 pending no tick", d, 0);
        tick_en = 1'b1; tk(3); rd(A_CAP, d); chk("R11 pending", d, 0);
        tk(1); rd(A_CAP, d); chk("R10 stopped", d, 32'h1234_5678);
        // R10 capture on a running channel
        wr(A_CNT+1, 100); wr(A_CEN, 2);
        tk(3); rd(A_CNT+1, v);
        wr(A_CAP, 32'h0000_0101);
        tk(3); rd(A_CAP, d); chk("R11 old snapshot", d, 32'h1234_5678);
        tk(1); rd(A_CAP, d); chk("R10 running", d, v + 5);
        // R11 second request ignored, bit0 clear ignored
        wr(A_CAP, 32'h0000_0201);
        wr(A_CAP, 32'h0000_0001);
        tk(3); rd(A_CAP, d); chk("R11 first kept", d, 32'h1234_5678);
        tk(5); rd(A_CAP, d); chk("R11 no queued", d, 32'h1234_5678);
        wr(A_CAP, 32'h0000_0100);
        tk(6); rd(A_CAP, d); chk("R11 no request", d, 32'h1234_5678);
        tick_en = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule